// File: doc/BRIEF.md
# Predicated Vector Loop Stepper

This block runs the element loop of a vector operation whose length is VL, where a predicate mask enables or disables each element. It keeps two step counters, one for the source side and one for the destination side. Each counter has its own mask register. Mask bit i stands for element i. On `start` the block captures VL, both starting steps, both masks and the predication mode. Software may set the starting steps to any value, so the block first drops the mask bits below each starting step. It then sequences the loop as a fixed series: wait for the mask, apply predication to the steps, then present the element.

Before each element, a single skip cycle moves each step straight to the next set bit of its mask. A trailing-zero priority encoder finds that bit. The zero bits and the set bit are shifted out of the mask register, and the count is added to the step. The block pulses `issue` once with the final step values and waits for `elem_done` from the execution side. The loop ends as soon as either step would reach VL. It also ends when a mask has no set bit left. In every case `loop_done` pulses once, including loops that present no element.

In twin mode the source and destination walk independent masks. In single mode the source mask drives both sides.

Top module: `vl_pred_stepper`

## Requirements
- R1: After reset `busy`, `issue` and `loop_done` are 0 and both steps read 0. A `start` taken in idle makes `busy` 1. When the loop has an element to present, the first `issue` is high exactly 3 cycles after the `start` edge, wherever the first set mask bit lies.
- R2: Each `issue` presents, on each side, the lowest element index at or above that side's current step whose mask bit is 1. Elements whose bit is 0 are never presented.
- R3: Mask bits below the starting step (bit i with i < starting step) are ignored, so a loop can resume from the middle.
- R4: If the next set bit on either side lies at index VL or above, the loop ends without an `issue`. Mask bits at or above VL have no effect.
- R5: On `elem_done` both steps advance by one and the next skip follows. If either advanced step would reach VL the loop ends instead, and `dst_step` stays at or below VL-1.
- R6: `loop_done` is a single-cycle pulse, given exactly once per loop. It is also given when no element is presented: an all-zero mask, VL = 0, or a starting step at or above VL.
- R7: When an `elem_done` ends the loop, `loop_done` is high in the cycle right after the `elem_done` cycle.
- R8: With `twin_in` = 1 the destination side follows `dst_mask_in`. With `twin_in` = 0 both sides follow `src_mask_in` and `dst_mask_in` is ignored.
- R9: `issue` is one cycle wide. No further `issue` comes before the `elem_done` that answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a loop (taken when idle) |
| vl_in | input | SW | Vector length, 0..MAXVL |
| src_step_in | input | SW | Starting source step |
| dst_step_in | input | SW | Starting destination step |
| src_mask_in | input | MAXVL | Source predicate, bit i = element i |
| dst_mask_in | input | MAXVL | Destination predicate, bit i = element i |
| twin_in | input | 1 | 1 = twin predication, 0 = single |
| elem_done | input | 1 | Execution finished the presented element |
| src_step | output | SW | Current source step |
| dst_step | output | SW | Current destination step |
| issue | output | 1 | One-cycle element strobe |
| busy | output | 1 | Loop in progress |
| loop_done | output | 1 | One-cycle loop completion pulse |

## Verification
The directed cases cover the following corners:
- A first set bit far up the mask. A design that walked one element per cycle would present it late.
- A resumed loop whose starting step lies above set bits. A design that did not drop the low bits would present stale elements.
- Masks with set bits beyond VL. A design that did not bound the skip would present an element at VL or above.
- An all-zero mask and a starting step at or above VL. A design that forgot the completion pulse here would hang the sequencer.
- A last element at VL-1, and a twin loop whose destination side runs out first. Here a faulty design would either push `dst_step` to VL or delay or repeat `loop_done` instead of pulsing it the cycle after `elem_done`.

// File: rtl/vl_step_pkg.sv
package vl_step_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_SKIP  = 3'd2,
      ST_ISSUE = 3'd3,
      ST_WAIT  = 3'd4
   } step_state_e;

   localparam int NUM_LANES = 2;
   localparam int LANE_SRC  = 0;
   localparam int LANE_DST  = 1;
endpackage

// File: rtl/vl_tz_encoder.sv
module vl_tz_encoder #(
   parameter int W  = 64,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          none
);
   // lowest set bit wins: scan downward so the last hit is the lowest index
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
   assign none = ~|vec;
endmodule

// File: rtl/vl_pred_lane.sv
module vl_pred_lane #(
   parameter int MAXVL = 64,
   parameter int SW    = $clog2(MAXVL + 1),
   localparam int IW   = $clog2(MAXVL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SW-1:0]    init_step,
   input  logic [MAXVL-1:0] init_mask,
   input  logic             fetch,
   input  logic             skip,
   input  logic             adv,
   output logic [SW-1:0]    step,
   output logic [SW:0]      skip_sum,
   output logic [SW:0]      next_sum,
   output logic             empty
);
   logic [MAXVL-1:0] mask_q;
   logic [SW-1:0]    step_q;
   logic [IW-1:0]    tz;

   vl_tz_encoder #(.W(MAXVL), .IW(IW)) u_tz (
      .vec  (mask_q),
      .idx  (tz),
      .none (empty)
   );

   assign skip_sum = {1'b0, step_q} + (SW+1)'(tz);
   assign next_sum = {1'b0, step_q} + (SW+1)'(1);
   assign step     = step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         step_q <= '0;
      end else if (load) begin
         mask_q <= init_mask;
         step_q <= init_step;
      end else if (fetch) begin
         mask_q <= mask_q >> step_q;
      end else if (skip) begin
         mask_q <= (mask_q >> tz) >> 1;
         step_q <= skip_sum[SW-1:0];
      end else if (adv) begin
         step_q <= next_sum[SW-1:0];
      end
   end
endmodule

// File: rtl/vl_pred_stepper.sv
module vl_pred_stepper
   import vl_step_pkg::*;
#(
   parameter int MAXVL = 64,
   parameter int SW    = $clog2(MAXVL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SW-1:0]    vl_in,
   input  logic [SW-1:0]    src_step_in,
   input  logic [SW-1:0]    dst_step_in,
   input  logic [MAXVL-1:0] src_mask_in,
   input  logic [MAXVL-1:0] dst_mask_in,
   input  logic             twin_in,
   input  logic             elem_done,
   output logic [SW-1:0]    src_step,
   output logic [SW-1:0]    dst_step,
   output logic             issue,
   output logic             busy,
   output logic             loop_done
);
   if (MAXVL < 2 || MAXVL > 64) begin : g_bad_maxvl
      $error("vl_pred_stepper: MAXVL must lie in 2..64");
   end
   if (SW < $clog2(MAXVL + 1)) begin : g_bad_sw
      $error("vl_pred_stepper: SW too narrow for MAXVL");
   end

   step_state_e      state_q;
   logic [SW-1:0]    vl_r;
   logic [SW-1:0]    step_w   [NUM_LANES];
   logic [SW:0]      skip_w   [NUM_LANES];
   logic [SW:0]      next_w   [NUM_LANES];
   logic             empty_w  [NUM_LANES];
   logic [SW-1:0]    init_s   [NUM_LANES];
   logic [MAXVL-1:0] init_m   [NUM_LANES];
   logic             adv_w    [NUM_LANES];
   logic             load_go, fetch_go, skip_go;
   logic             start_bad, skip_end, step_end;

   assign init_s[LANE_SRC] = src_step_in;
   assign init_s[LANE_DST] = dst_step_in;
   assign init_m[LANE_SRC] = src_mask_in;
   assign init_m[LANE_DST] = twin_in ? dst_mask_in : src_mask_in;

   assign start_bad = (vl_r == '0) || (step_w[LANE_SRC] >= vl_r) ||
                      (step_w[LANE_DST] >= vl_r);
   assign skip_end  = empty_w[LANE_SRC] || empty_w[LANE_DST] ||
                      (skip_w[LANE_SRC] >= {1'b0, vl_r}) ||
                      (skip_w[LANE_DST] >= {1'b0, vl_r});
   assign step_end  = (next_w[LANE_SRC] >= {1'b0, vl_r}) ||
                      (next_w[LANE_DST] >= {1'b0, vl_r});

   assign load_go  = (state_q == ST_IDLE) && start;
   assign fetch_go = (state_q == ST_FETCH);
   assign skip_go  = (state_q == ST_SKIP) && !skip_end;

   // source may reach VL on the final advance; destination only when not ending
   assign adv_w[LANE_SRC] = (state_q == ST_WAIT) && elem_done;
   assign adv_w[LANE_DST] = (state_q == ST_WAIT) && elem_done && !step_end;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      vl_pred_lane #(.MAXVL(MAXVL), .SW(SW)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load_go),
         .init_step (init_s[g]),
         .init_mask (init_m[g]),
         .fetch     (fetch_go),
         .skip      (skip_go),
         .adv       (adv_w[g]),
         .step      (step_w[g]),
         .skip_sum  (skip_w[g]),
         .next_sum  (next_w[g]),
         .empty     (empty_w[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         vl_r      <= '0;
         loop_done <= 1'b0;
      end else begin
         loop_done <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               vl_r    <= vl_in;
               state_q <= ST_FETCH;
            end
            ST_FETCH: begin
               if (start_bad) begin
                  loop_done <= 1'b1;
                  state_q   <= ST_IDLE;
               end else begin
                  state_q <= ST_SKIP;
               end
            end
            ST_SKIP: begin
               if (skip_end) begin
                  loop_done <= 1'b1;
                  state_q   <= ST_IDLE;
               end else begin
                  state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT: if (elem_done) begin
               if (step_end) begin
                  loop_done <= 1'b1;
                  state_q   <= ST_IDLE;
               end else begin
                  state_q <= ST_SKIP;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign issue    = (state_q == ST_ISSUE);
   assign busy     = (state_q != ST_IDLE);
   assign src_step = step_w[LANE_SRC];
   assign dst_step = step_w[LANE_DST];
endmodule

// File: rtl/vl_pred_stepper_chk.sv
module vl_pred_stepper_chk #(
   parameter int SW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          issue,
   input logic          elem_done,
   input logic          loop_done,
   input logic [SW-1:0] src_step,
   input logic [SW-1:0] dst_step,
   input logic [SW-1:0] vl_r
);
   // R1
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R2
   issue_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> (src_step < vl_r) && (dst_step < vl_r));

   // R5
   dst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loop_done |-> (vl_r == '0) || (dst_step < vl_r) || $stable(dst_step));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loop_done |=> !loop_done);

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loop_done |-> !busy && !issue);

   // R9
   issue_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> !issue);

   // R9
   issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue ##1 !elem_done) |=> !issue);
endmodule

bind vl_pred_stepper vl_pred_stepper_chk #(.SW(SW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .issue     (issue),
   .elem_done (elem_done),
   .loop_done (loop_done),
   .src_step  (src_step),
   .dst_step  (dst_step),
   .vl_r      (vl_r)
);

// File: tb/vl_pred_stepper_bench.sv
`timescale 1ns/1ps
module vl_pred_stepper_bench;
   localparam int MAXVL = 64;
   localparam int SW    = $clog2(MAXVL + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [SW-1:0]    vl_in = '0;
   logic [SW-1:0]    src_step_in = '0;
   logic [SW-1:0]    dst_step_in = '0;
   logic [MAXVL-1:0] src_mask_in = '0;
   logic [MAXVL-1:0] dst_mask_in = '0;
   logic             twin_in = 1'b0;
   logic             elem_done = 1'b0;
   logic [SW-1:0]    src_step, dst_step;
   logic             issue, busy, loop_done;

   int n_chk = 0;
   int n_bad = 0;

   int exp_s [64];
   int exp_d [64];
   int exp_n;
   int got_s [64];
   int got_d [64];
   int got_n;
   int done_cnt, done_cyc, ed_cyc, first_issue_cyc;
   int fin_dst;

   always #2.5 clk = ~clk;

   vl_pred_stepper #(.MAXVL(MAXVL), .SW(SW)) u_vl_pred_stepper (
      .clk, .rst_n, .start, .vl_in, .src_step_in, .dst_step_in,
      .src_mask_in, .dst_mask_in, .twin_in, .elem_done,
      .src_step, .dst_step, .issue, .busy, .loop_done
   );

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish (got hang, expected end)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // reference: index search over the raw masks
   task automatic build_exp(input int vl, input int s0, input int d0,
                            input logic [63:0] ms, input logic [63:0] md,
                            input bit twin);
      logic [63:0] mdx;
      int s, d, ns, nd;
      mdx = twin ? md : ms;
      s = s0; d = d0; exp_n = 0;
      forever begin
         if (s >= vl || d >= vl) break;
         ns = s; while (ns < vl && !ms[ns]) ns++;
         nd = d; while (nd < vl && !mdx[nd]) nd++;
         if (ns >= vl || nd >= vl) break;
         exp_s[exp_n] = ns; exp_d[exp_n] = nd; exp_n++;
         s = ns + 1; d = nd + 1;
      end
   endtask

   task automatic run_loop(input int vl, input int s0, input int d0,
                           input logic [63:0] ms, input logic [63:0] md,
                           input bit twin);
      int cyc;
      bit pend;
      @(negedge clk);
      vl_in = SW'(vl); src_step_in = SW'(s0); dst_step_in = SW'(d0);
      src_mask_in = ms; dst_mask_in = md; twin_in = twin;
      start = 1'b1;
      got_n = 0; done_cnt = 0; done_cyc = -1; ed_cyc = -1;
      first_issue_cyc = -1; cyc = 0; pend = 0;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         start = 1'b0;
         cyc++;
         elem_done = 1'b0;
         if (loop_done) begin
            done_cnt++;
            if (done_cyc < 0) done_cyc = cyc;
         end
         if (issue) begin
            if (first_issue_cyc < 0) first_issue_cyc = cyc;
            if (got_n < 64) begin
               got_s[got_n] = int'(src_step); got_d[got_n] = int'(dst_step);
            end
            got_n++;
            pend = 1;
         end else if (pend) begin
            elem_done = 1'b1; ed_cyc = cyc; pend = 0;
         end
         if (done_cyc >= 0 && cyc >= done_cyc + 3) break;
      end
      fin_dst = int'(dst_step);
   endtask

   task automatic compare(input string req);
      check({req, " element count"}, got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++) begin
         check({req, " src step"}, got_s[i], exp_s[i]);
         check({req, " dst step"}, got_d[i], exp_d[i]);
      end
      check("R6 single loop_done", done_cnt, 1);
   endtask

   task automatic t_reset();
      check("R1 reset busy", int'(busy), 0);
      check("R1 reset issue", int'(issue), 0);
      check("R1 reset loop_done", int'(loop_done), 0);
      check("R1 reset src_step", int'(src_step), 0);
      check("R1 reset dst_step", int'(dst_step), 0);
   endtask

   task automatic t_all_ones();
      build_exp(8, 0, 0, 64'hFF, 64'h0, 0);
      run_loop(8, 0, 0, 64'hFF, 64'h0, 0);
      compare("R2 dense");
      check("R5 final dst at VL-1", fin_dst, 7);
   endtask

   task automatic t_sparse();
      build_exp(16, 0, 0, 64'h8421, 64'h0, 0);
      run_loop(16, 0, 0, 64'h8421, 64'h0, 0);
      compare("R2 sparse");
   endtask

   task automatic t_twin();
      build_exp(8, 0, 0, 64'b1011, 64'b11100, 1);
      run_loop(8, 0, 0, 64'b1011, 64'b11100, 1);
      compare("R8 twin");
   endtask

   task automatic t_resume();
      build_exp(10, 4, 4, 64'h146, 64'h0, 0);
      run_loop(10, 4, 4, 64'h146, 64'h0, 0);
      compare("R3 resume");
      check("R3 first element", got_s[0], 6);
   endtask

   task automatic t_zero_mask();
      run_loop(20, 0, 0, 64'h0, 64'h0, 0);
      check("R6 zero mask no issue", got_n, 0);
      check("R6 zero mask done", done_cnt, 1);
      check("R6 zero mask done cycle", done_cyc, 3);
   endtask

   task automatic t_start_past();
      run_loop(10, 12, 0, 64'hFFFF, 64'h0, 0);
      check("R6 start past VL no issue", got_n, 0);
      check("R6 start past VL done cycle", done_cyc, 2);
      run_loop(0, 0, 0, 64'hFFFF, 64'h0, 0);
      check("R6 VL zero no issue", got_n, 0);
      check("R6 VL zero done", done_cnt, 1);
   endtask

   task automatic t_beyond_vl();
      build_exp(5, 0, 0, 64'h0000_0100_0000_0004, 64'h0, 0);
      run_loop(5, 0, 0, 64'h0000_0100_0000_0004, 64'h0, 0);
      compare("R4 bits past VL");
   endtask

   task automatic t_latency();
      run_loop(64, 0, 0, 64'h0004_0000_0000_0000, 64'h0, 0);
      check("R1 first issue latency far bit", first_issue_cyc, 3);
      check("R2 far bit src", got_s[0], 50);
      run_loop(64, 0, 0, 64'h1, 64'h0, 0);
      check("R1 first issue latency bit 0", first_issue_cyc, 3);
   endtask

   task automatic t_back_to_back();
      run_loop(6, 0, 0, 64'h20, 64'h0, 0);
      check("R7 element count", got_n, 1);
      check("R7 done one cycle after elem_done", done_cyc - ed_cyc, 1);
      check("R5 dst held at VL-1", fin_dst, 5);
   endtask

   task automatic t_single_ignores_dst();
      build_exp(8, 0, 0, 64'h0A, 64'hF0, 0);
      run_loop(8, 0, 0, 64'h0A, 64'hF0, 0);
      compare("R8 single mode");
      check("R8 dst follows src mask", got_d[0], 1);
   endtask

   task automatic t_dst_first_end();
      build_exp(8, 0, 0, 64'hFF, 64'h80, 1);
      run_loop(8, 0, 0, 64'hFF, 64'h80, 1);
      compare("R5 dst reaches end");
      check("R5 dst not past VL-1", fin_dst, 7);
      check("R7 done after dst end", done_cyc - ed_cyc, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_all_ones();
      t_sparse();
      t_twin();
      t_resume();
      t_zero_mask();
      t_start_past();
      t_beyond_vl();
      t_latency();
      t_back_to_back();
      t_single_ignores_dst();
      t_dst_first_end();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule